// File: doc/BRIEF.md
# Multi-PHY receive cell port

This block is the PHY-side receive port that hands complete ATM cells, already held in an internal receive cell FIFO, to an ATM layer device. It runs on the receive clock that the layer device supplies. Toward the layer device it drives a data bus of `DATA_W` bits (16 by default, 8 allowed), a start-of-cell marker and an odd-parity bit. It also drives a cell-available flag. Each output comes with an output-enable that models the tri-state pad.

Toward the FIFO the block is a valid/ready sink. The FIFO presents a word with `fifo_valid`. The block takes that word on a rising edge where both `fifo_valid` and `fifo_ready` are high, and each such edge pops exactly one word. Back-pressure comes only from the block: `fifo_ready` drops when the layer device deasserts its active-low read enable or deselects this PHY. It also drops at a cell boundary when no complete cell is waiting. `fifo_ready` never depends on `fifo_valid`. `fifo_cells` reports how many complete cells the FIFO holds, and a cell that has been partly read still counts until its last word is popped.

In multi-PHY mode the layer device polls and selects PHYs with a 5-bit address, which is compared with a programmed address value. In single-PHY mode the address is ignored.

Top module: `cellrx_phy_port`

## Requirements
- R1: While `rst` is high on a clock edge, the next cycle shows `bus_oe`, `clav_oe`, `rx_valid`, `rx_soc` and `fifo_ready` all low, and the word index returns to the start of a cell.
- R2: In multi-PHY mode (`multi_phy`=1), `clav_oe` is high in the cycle after an edge at which `addr_in` equals `own_addr`, and low after an edge where they differ.
- R3: When `clav_oe` is high, `clav` is 1 exactly when a whole unread cell remains. At a cell boundary that means `fifo_cells`>=1. Mid-cell it means `fifo_cells`>=2.
- R4: The port is selected by the address match sampled on the last edge at which `rd_en_n` was high. `bus_oe` equals that selection, and a deselected port tri-states data, start-of-cell and parity.
- R5: `fifo_ready` is high only while the port is selected and `rd_en_n` is low; each edge with `fifo_ready` and `fifo_valid` high pops one word.
- R6: A word popped at an edge appears on `rx_data` with `rx_valid`=1 in the following cycle. `rx_valid` is 0 in every other cycle, and `rx_data` then holds its last value.
- R7: `rx_soc` is 1 only together with the first word of a cell.
- R8: `rx_par` makes the count of ones in {`rx_data`,`rx_par`} odd. It is 1 out of reset, when `rx_data` is 0.
- R9: A cell is 27 words when `DATA_W`=16 (header, pad word, payload) and 53 bytes when `DATA_W`=8. The word after the last of a cell carries `rx_soc`.
- R10: Deasserting `rd_en_n` mid-cell pauses the transfer. Reasserting it resumes at the next unsent word of the same cell.
- R11: At a cell boundary with `fifo_cells`=0, `fifo_ready` stays low even when the read enable is asserted.
- R12: In single-PHY mode `addr_in` has no effect: `clav_oe` is high after any edge outside reset, and any edge with `rd_en_n` high selects the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock from the layer device |
| rst | input | 1 | Synchronous active-high reset |
| multi_phy | input | 1 | 1 selects multi-PHY address decoding |
| own_addr | input | 5 | Programmed receive address value |
| addr_in | input | 5 | Poll/select address, bit 4 MSB |
| rd_en_n | input | 1 | Active-low read enable |
| fifo_data | input | DATA_W | Word at the FIFO head |
| fifo_valid | input | 1 | FIFO head word is present |
| fifo_cells | input | CNT_W | Complete cells held in the FIFO |
| fifo_ready | output | 1 | Pop strobe, qualified by fifo_valid |
| rx_data | output | DATA_W | Receive data bus |
| rx_soc | output | 1 | Start-of-cell marker |
| rx_par | output | 1 | Odd parity of rx_data |
| rx_valid | output | 1 | A new word is on rx_data this cycle |
| bus_oe | output | 1 | Drive enable for rx_data, rx_soc, rx_par |
| clav | output | 1 | Cell-available value |
| clav_oe | output | 1 | Drive enable for clav |

## Verification
The main function is tried with several input patterns.

- A continuous read of two back-to-back cells checks framing, parity and the point where `clav` falls mid-cell while the last cell drains.
- A mid-cell pause combined with a poll of another address separates the selection latched during the read-enable-high gap from the one latched during the read. It also shows that the cell resumes at the correct word.
- A read with the FIFO drained checks that no new cell starts.
- A single-PHY pass with an arbitrary address checks that the address is ignored.

The bench's cycle model compares every enable, strobe and bus value on every clock, so a slip of one cycle or one word shows up at once.

// File: rtl/cellrx_pkg.sv
package cellrx_pkg;
  // Words per cell for a given bus width: 16-bit bus carries a pad word
  function automatic int cell_words(input int dw);
    return (dw == 16) ? 27 : 53;
  endfunction

  typedef struct packed {
    logic first;
    logic take;
  } seq_evt_t;
endpackage

// File: rtl/cellrx_select.sv
module cellrx_select #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              multi_phy,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rd_en_n,
  output logic              sel,
  output logic              clav_oe
);
  logic hit;

  assign hit = multi_phy ? (addr_in == own_addr) : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel     <= 1'b0;
      clav_oe <= 1'b0;
    end else begin
      clav_oe <= hit;
      if (rd_en_n) sel <= hit;
    end
  end
endmodule

// File: rtl/cellrx_seq.sv
module cellrx_seq
  import cellrx_pkg::*;
#(
  parameter int CELL_W = 27,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             fifo_valid,
  input  logic [CNT_W-1:0] fifo_cells,
  output logic             fifo_ready,
  output seq_evt_t         evt,
  output logic             clav
);
  localparam int IDX_W = $clog2(CELL_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_W - 1);

  logic [IDX_W-1:0] idx;
  logic             mid;
  logic             have_one;
  logic             have_two;

  assign mid      = (idx != '0);
  assign have_one = (fifo_cells != '0);
  assign have_two = (fifo_cells > CNT_W'(1));

  assign fifo_ready = go && (mid || have_one);
  assign clav       = mid ? have_two : have_one;
  assign evt.take   = fifo_ready && fifo_valid;
  assign evt.first  = !mid;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (evt.take) begin
      idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
  end
endmodule

// File: rtl/cellrx_outreg.sv
module cellrx_outreg
  import cellrx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_evt_t          evt,
  input  logic [DATA_W-1:0] fifo_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_par,
  output logic              rx_soc,
  output logic              rx_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      rx_par   <= 1'b1;
      rx_soc   <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= evt.take;
      if (evt.take) begin
        rx_data <= fifo_data;
        rx_par  <= ~(^fifo_data);
        rx_soc  <= evt.first;
      end else begin
        rx_soc  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cellrx_phy_port.sv
module cellrx_phy_port
  import cellrx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              multi_phy,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rd_en_n,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_valid,
  input  logic [CNT_W-1:0]  fifo_cells,
  output logic              fifo_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_soc,
  output logic              rx_par,
  output logic              rx_valid,
  output logic              bus_oe,
  output logic              clav,
  output logic              clav_oe
);
  localparam int CELL_W = cell_words(DATA_W);

  logic     sel;
  seq_evt_t evt;

  generate
    if (DATA_W != 8 && DATA_W != 16) begin : g_bad_width
      initial $error("cellrx_phy_port: DATA_W must be 8 or 16");
    end
  endgenerate

  cellrx_select #(.ADDR_W(ADDR_W)) u_sel (
    .clk(clk), .rst(rst), .multi_phy(multi_phy), .own_addr(own_addr),
    .addr_in(addr_in), .rd_en_n(rd_en_n), .sel(sel), .clav_oe(clav_oe)
  );

  cellrx_seq #(.CELL_W(CELL_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .go(sel && !rd_en_n), .fifo_valid(fifo_valid),
    .fifo_cells(fifo_cells), .fifo_ready(fifo_ready), .evt(evt), .clav(clav)
  );

  cellrx_outreg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .evt(evt), .fifo_data(fifo_data),
    .rx_data(rx_data), .rx_par(rx_par), .rx_soc(rx_soc), .rx_valid(rx_valid)
  );

  assign bus_oe = sel;
endmodule

// File: rtl/cellrx_phy_port_chk.sv
module cellrx_phy_port_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              multi_phy,
  input logic [ADDR_W-1:0] own_addr,
  input logic [ADDR_W-1:0] addr_in,
  input logic              rd_en_n,
  input logic [DATA_W-1:0] fifo_data,
  input logic              fifo_valid,
  input logic [CNT_W-1:0]  fifo_cells,
  input logic              fifo_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_soc,
  input logic              rx_par,
  input logic              rx_valid,
  input logic              bus_oe,
  input logic              clav,
  input logic              clav_oe
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!bus_oe && !clav_oe && !rx_valid && !rx_soc));

  p_clav_hiz_r2: assert property (@(posedge clk) disable iff (rst)
    (multi_phy && addr_in != own_addr) |=> !clav_oe);

  p_clav_empty_r3: assert property (@(posedge clk) disable iff (rst)
    (fifo_cells == '0) |-> !clav);

  p_ready_needs_sel_r5: assert property (@(posedge clk) disable iff (rst)
    fifo_ready |-> (bus_oe && !rd_en_n));

  p_word_follows_pop_r6: assert property (@(posedge clk) disable iff (rst)
    (fifo_ready && fifo_valid) |=> (rx_valid && rx_data == $past(fifo_data)));

  p_odd_parity_r8: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> (^{rx_data, rx_par}) == 1'b1);

  p_pause_stops_r10: assert property (@(posedge clk) disable iff (rst)
    rd_en_n |=> !rx_valid);

  p_soc_with_word_r7: assert property (@(posedge clk) disable iff (rst)
    rx_soc |-> rx_valid);
endmodule

bind cellrx_phy_port cellrx_phy_port_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/cellrx_phy_port_test.sv
module cellrx_phy_port_test;
  localparam int DW = 16;
  localparam int CW = 27;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          multi_phy = 1'b1;
  logic [4:0]    own_addr = 5'h13;
  logic [4:0]    addr_in = 5'h00;
  logic          rd_en_n = 1'b1;
  logic [DW-1:0] fifo_data = '0;
  logic          fifo_valid = 1'b0;
  logic [3:0]    fifo_cells = '0;
  logic          fifo_ready, rx_soc, rx_par, rx_valid, bus_oe, clav, clav_oe;
  logic [DW-1:0] rx_data;

  cellrx_phy_port uut (
    .clk(clk), .rst(rst), .multi_phy(multi_phy), .own_addr(own_addr),
    .addr_in(addr_in), .rd_en_n(rd_en_n), .fifo_data(fifo_data),
    .fifo_valid(fifo_valid), .fifo_cells(fifo_cells), .fifo_ready(fifo_ready),
    .rx_data(rx_data), .rx_soc(rx_soc), .rx_par(rx_par), .rx_valid(rx_valid),
    .bus_oe(bus_oe), .clav(clav), .clav_oe(clav_oe)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  logic [DW-1:0] q[$];
  bit m_sel = 0, m_coe = 0, m_vld = 0, m_soc = 0, m_par = 1;
  int m_idx = 0;
  logic [DW-1:0] m_data = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // model update on the edge, from inputs that settled a cycle earlier
  always @(posedge clk) begin
    bit hit, rdy, take;
    cycles++;
    hit  = multi_phy ? (addr_in == own_addr) : 1'b1;
    rdy  = m_sel && !rd_en_n && (m_idx != 0 || fifo_cells != 0);
    take = rdy && fifo_valid;
    if (rst) begin
      m_sel = 0; m_coe = 0; m_vld = 0; m_soc = 0; m_idx = 0;
      m_data = '0; m_par = 1;
    end else begin
      m_vld = take;
      m_soc = 0;
      if (take) begin
        m_data = q.pop_front();
        m_par  = ~(^m_data);
        m_soc  = (m_idx == 0);
        m_idx  = (m_idx + 1) % CW;
      end
      m_coe = hit;
      if (rd_en_n) m_sel = hit;
    end
  end

  // FIFO model outputs, driven after the edge
  always @(posedge clk) begin
    #2;
    fifo_valid = (q.size() != 0);
    fifo_data  = (q.size() != 0) ? q[0] : '0;
    fifo_cells = 4'((q.size() + CW - 1) / CW);
  end

  // compare every cycle away from the edge
  always @(negedge clk) begin
    bit e_rdy, e_clav;
    if (!done && cycles > 0) begin
      e_rdy  = m_sel && !rd_en_n && (m_idx != 0 || fifo_cells != 0);
      e_clav = (m_idx != 0) ? (fifo_cells >= 2) : (fifo_cells >= 1);
      chk(fifo_ready === e_rdy, "R5/R11 fifo_ready", fifo_ready, e_rdy);
      chk(clav_oe === m_coe, "R2/R12 clav_oe", clav_oe, m_coe);
      chk(bus_oe === m_sel, "R4 bus_oe", bus_oe, m_sel);
      chk(rx_valid === m_vld, "R6/R10 rx_valid", rx_valid, m_vld);
      chk(rx_soc === m_soc, "R7/R9 rx_soc", rx_soc, m_soc);
      chk(rx_data === m_data, "R6 rx_data", rx_data, m_data);
      chk(rx_par === m_par, "R8 rx_par", rx_par, m_par);
      if (m_coe) chk(clav === e_clav, "R3 clav", clav, e_clav);
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic push_cell(input int base);
    for (int i = 0; i < CW; i++)
      q.push_back(DW'((base << 12) ^ (i * 16'h1357) ^ (i << 3)));
  endtask

  always @(posedge clk) begin
    if (cycles == 5000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 0;
    #8;
    // R1: reset state seen at the ports
    chk(!bus_oe && !clav_oe && !rx_valid && !fifo_ready, "R1 reset quiet",
        {bus_oe, clav_oe, rx_valid, fifo_ready}, 0);
    tick(4);                       // R2: mismatched address, clav tri-stated
    push_cell(1);
    push_cell(2);
    addr_in = 5'h13;
    tick(2);
    rd_en_n = 0;
    tick(10);
    rd_en_n = 1;                   // R10: pause mid-cell, poll another PHY
    addr_in = 5'h07;
    tick(3);
    rd_en_n = 0;                   // deselected: nothing moves (R4)
    tick(3);
    rd_en_n = 1;
    addr_in = 5'h13;
    tick(1);
    rd_en_n = 0;                   // resumes same cell
    tick(60);                      // R9 cell boundary, R3 mid-cell clav drop
    tick(5);                       // R11 drained: no start
    rd_en_n = 1;
    multi_phy = 0;                 // R12 single-PHY, address ignored
    addr_in = 5'h02;
    tick(2);
    push_cell(3);
    rd_en_n = 0;
    tick(12);
    rd_en_n = 1;
    addr_in = 5'h1f;
    tick(2);
    rd_en_n = 0;
    tick(22);
    rst = 1;                       // R1 again mid-traffic
    push_cell(4);
    tick(2);
    rst = 0;
    tick(3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule